// File: doc/BRIEF.md
# Triggered Output Pattern Buffer

This block holds the next pattern that a group of port pins will show, and moves it onto the pins only when a hardware trigger arrives. The pattern is kept in two small buffers: a 4-bit low part and a 2-bit high part. Software reaches them on a simple peripheral bus through two separate addresses, with either whole-byte or single-bit accesses. A one-cycle trigger pulse copies the buffers into an output latch that drives the pins until the next trigger.

A mode input sets how writes are steered. In split mode each address owns its own part: a write through the low address changes only the low nibble, and a write through the high address changes only the two high bits. In joint mode one write through either address loads the whole six-bit pattern. In both modes, a read through either address returns the whole pattern. Software is expected to load the buffers before the trigger that should publish them.

Top module: `rto_buf_top`

## Requirements
- R1: While `rst` is high at a clock edge, both buffers and the output latch become zero, so `out_lo`, `out_hi` and the read value are all zero afterwards.
- R2: In split mode (`mode_joint`=0), a write with `bus_addr`=0 (low address) replaces only the low buffer with write-byte bits 3:0. The high buffer keeps its value.
- R3: In split mode, a write with `bus_addr`=1 (high address) replaces only the high buffer with write-byte bits 5:4. The low buffer keeps its value.
- R4: In joint mode (`mode_joint`=1), a write through either address loads write-byte bits 3:0 into the low buffer and bits 5:4 into the high buffer in the same cycle.
- R5: A read (`bus_sel`=1, `bus_wr`=0) through either address returns {2'b00, high buffer, low buffer} on `bus_rdata`. Bits 7:6 always read as 0, and write-byte bits 7:6 are discarded. `bus_rdata` is zero when no read is selected.
- R6: A single-bit write (`bus_bit`=1) takes the current combined byte, sets bit `bus_bit_idx` to `bus_wdata[0]`, and then steers that byte as in R2 to R4. A bit that falls outside the part owned by the address in split mode changes nothing.
- R7: On a clock edge with `trig`=1, the output latch takes the buffer contents. Without a trigger it holds its value, and bus writes never change it.
- R8: When a write and a trigger land in the same cycle, the latch captures the buffer value from before the write, and the buffer takes the new value.
- R9: `out_lo` carries latch bits 3:0 and `out_hi` carries latch bits 5:4, as two independent output groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_joint | input | 1 | 0: split steering, 1: joint six-bit steering |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 1 | 0 low buffer address, 1 high buffer address |
| bus_bit | input | 1 | 1 selects a single-bit access |
| bus_bit_idx | input | 3 | Bit position for a single-bit write |
| bus_wdata | input | 8 | Write byte; bit 0 is the value in a single-bit write |
| bus_rdata | output | 8 | Combined read value |
| trig | input | 1 | One-cycle output trigger |
| out_lo | output | 4 | Low output group |
| out_hi | output | 2 | High output group |

## Verification
The bench goes after cross-talk between the two parts. A split-mode write that leaks into the other part would show up as a wrong read value after a high-address write, or after a single-bit write that targets the wrong part. It checks that reserved write bits are dropped, and that a joint write through the high address still loads the low nibble. It also fires a trigger in the same cycle as a write: a latch that takes the new value, or that follows bus writes at all, would show the wrong value on the output pins.

// File: rtl/rto_pkg.sv
package rto_pkg;
    localparam int LO_W   = 4;
    localparam int HI_W   = 2;
    localparam int PAT_W  = LO_W + HI_W;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic {
        ADDR_LO = 1'b0,
        ADDR_HI = 1'b1
    } addr_e;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_JOINT = 1'b1
    } mode_e;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } pat_t;

    typedef struct packed {
        logic en_lo;
        logic en_hi;
        pat_t nxt;
    } upd_t;

    function automatic logic [BYTE_W-1:0] pat_to_byte(input pat_t p);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[PAT_W-1:0] = p;
        return b;
    endfunction

    function automatic pat_t byte_to_pat(input logic [BYTE_W-1:0] b);
        return pat_t'(b[PAT_W-1:0]);
    endfunction
endpackage

// File: rtl/rto_bus_decode.sv
module rto_bus_decode
    import rto_pkg::*;
(
    input  pat_t              cur,
    input  logic              sel,
    input  logic              wr,
    input  addr_e             addr,
    input  mode_e             mode,
    input  logic              bit_acc,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [BYTE_W-1:0] wdata,
    output upd_t              upd
);
    logic [BYTE_W-1:0] img;
    logic [BYTE_W-1:0] cur_b;
    logic              wr_act;

    always_comb begin
        cur_b = pat_to_byte(cur);
        img   = cur_b;
        if (bit_acc) begin
            for (int i = 0; i < BYTE_W; i++) begin
                if (bit_idx == IDX_W'(i)) img[i] = wdata[0];
            end
        end else begin
            img = wdata;
        end
    end

    assign wr_act = sel && wr;

    always_comb begin
        upd.nxt   = byte_to_pat(img);
        upd.en_lo = wr_act && ((mode == MODE_JOINT) || (addr == ADDR_LO));
        upd.en_hi = wr_act && ((mode == MODE_JOINT) || (addr == ADDR_HI));
    end
endmodule

// File: rtl/rto_buffer.sv
module rto_buffer
    import rto_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  upd_t upd,
    output pat_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (upd.en_lo) q.lo <= upd.nxt.lo;
            if (upd.en_hi) q.hi <= upd.nxt.hi;
        end
    end
endmodule

// File: rtl/rto_out_latch.sv
module rto_out_latch
    import rto_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  pat_t src,
    output pat_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (trig) q <= src;
    end
endmodule

// File: rtl/rto_buf_top.sv
module rto_buf_top
    import rto_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_joint,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic              bus_bit,
    input  logic [IDX_W-1:0]  bus_bit_idx,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              trig,
    output logic [LO_W-1:0]   out_lo,
    output logic [HI_W-1:0]   out_hi
);
    pat_t buf_q;
    pat_t lat_q;
    upd_t upd;

    rto_bus_decode u_dec (
        .cur     (buf_q),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (addr_e'(bus_addr)),
        .mode    (mode_e'(mode_joint)),
        .bit_acc (bus_bit),
        .bit_idx (bus_bit_idx),
        .wdata   (bus_wdata),
        .upd     (upd)
    );

    rto_buffer u_buf (
        .clk (clk),
        .rst (rst),
        .upd (upd),
        .q   (buf_q)
    );

    rto_out_latch u_lat (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .src  (buf_q),
        .q    (lat_q)
    );

    assign bus_rdata = (bus_sel && !bus_wr) ? pat_to_byte(buf_q) : '0;
    assign out_lo    = lat_q.lo;
    assign out_hi    = lat_q.hi;
endmodule

// File: rtl/rto_buf_chk.sv
module rto_buf_chk
    import rto_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode_joint,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              trig,
    input logic [LO_W-1:0]   out_lo,
    input logic [HI_W-1:0]   out_hi,
    input pat_t              buf_q,
    input pat_t              lat_q
);
    logic wr_now;
    assign wr_now = bus_sel && bus_wr;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (buf_q == '0 && lat_q == '0));

    p_split_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_now && !mode_joint && !bus_addr) |=> $stable(buf_q.hi));

    p_split_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_now && !mode_joint && bus_addr) |=> $stable(buf_q.lo));

    p_rsvd_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BYTE_W-1:PAT_W] == '0);

    p_no_write_holds_buf_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_now |=> $stable(buf_q));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !trig |=> ($stable(out_lo) && $stable(out_hi)));

    p_capture_old_r8: assert property (@(posedge clk) disable iff (rst)
        trig |=> (lat_q == $past(buf_q)));

    p_pin_groups_r9: assert property (@(posedge clk) disable iff (rst)
        (out_lo == lat_q.lo) && (out_hi == lat_q.hi));
endmodule

bind rto_buf_top rto_buf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_joint (mode_joint),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .trig       (trig),
    .out_lo     (out_lo),
    .out_hi     (out_hi),
    .buf_q      (buf_q),
    .lat_q      (lat_q)
);

// File: tb/sim_rto_buf_top.sv
`timescale 1ns/1ps
module sim_rto_buf_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_joint;
    logic       bus_sel;
    logic       bus_wr;
    logic       bus_addr;
    logic       bus_bit;
    logic [2:0] bus_bit_idx;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       trig;
    logic [3:0] out_lo;
    logic [1:0] out_hi;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rto_buf_top u0 (
        .clk(clk), .rst(rst), .mode_joint(mode_joint), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_bit(bus_bit),
        .bus_bit_idx(bus_bit_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig(trig), .out_lo(out_lo), .out_hi(out_hi)
    );

    // {mode, addr, bit, idx[2:0], wdata[7:0], expected combined read[7:0]}
    localparam int NV = 13;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 3'd0, 8'hA5, 8'h05},  // R2
        {1'b0, 1'b1, 1'b0, 3'd0, 8'hFF, 8'h35},  // R3, R5 reserved dropped
        {1'b0, 1'b0, 1'b0, 3'd0, 8'h0C, 8'h3C},  // R2
        {1'b0, 1'b1, 1'b0, 3'd0, 8'h10, 8'h1C},  // R3
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h2A, 8'h2A},  // R4 via low
        {1'b1, 1'b1, 1'b0, 3'd0, 8'hD7, 8'h17},  // R4 via high
        {1'b0, 1'b0, 1'b1, 3'd3, 8'h01, 8'h1F},  // R6
        {1'b0, 1'b0, 1'b1, 3'd5, 8'h01, 8'h1F},  // R6 outside low part
        {1'b0, 1'b1, 1'b1, 3'd5, 8'h01, 8'h3F},  // R6
        {1'b0, 1'b1, 1'b1, 3'd0, 8'h00, 8'h3F},  // R6 outside high part
        {1'b1, 1'b1, 1'b1, 3'd0, 8'h00, 8'h3E},  // R6 joint
        {1'b1, 1'b0, 1'b1, 3'd4, 8'h00, 8'h2E},  // R6 joint
        {1'b1, 1'b0, 1'b1, 3'd7, 8'h01, 8'h2E}   // R6 reserved bit
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_bit = 1'b0; trig = 1'b0;
    endtask

    task automatic bus_write(input logic m, input logic a, input logic b,
                             input logic [2:0] idx, input logic [7:0] d, input logic t);
        @(negedge clk);
        mode_joint = m; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a;
        bus_bit = b; bus_bit_idx = idx; bus_wdata = d; trig = t;
        @(negedge clk);
        idle();
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; mode_joint = 1'b0; bus_addr = 1'b0; bus_bit_idx = '0;
        bus_wdata = '0; idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        bus_read(1'b0, v);  check("R1 read", v, 8'h00);
        check("R1 out", {2'b00, out_hi, out_lo}, 8'h00);

        // vector table: write then read through both addresses (R5)
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18:16], VEC[i][15:8], 1'b0);
            bus_read(1'b0, v);  check($sformatf("R2-6 vec%0d lo addr", i), v, VEC[i][7:0]);
            bus_read(1'b1, v);  check($sformatf("R5 vec%0d hi addr", i), v, VEC[i][7:0]);
        end

        // R7 writes never reach the latch
        check("R7 no trig", {2'b00, out_hi, out_lo}, 8'h00);

        // R7 / R9 trigger copies buffer 2E
        pulse_trig();
        check("R9 out_lo", {4'h0, out_lo}, 8'h0E);
        check("R9 out_hi", {6'h0, out_hi}, 8'h02);

        // R8 write and trigger together
        bus_write(1'b1, 1'b0, 1'b0, 3'd0, 8'h15, 1'b1);
        check("R8 latch old", {2'b00, out_hi, out_lo}, 8'h2E);
        bus_read(1'b1, v);  check("R8 buffer new", v, 8'h15);

        // R7 hold after write without trigger
        bus_write(1'b0, 1'b1, 1'b0, 3'd0, 8'h20, 1'b0);
        check("R7 hold", {2'b00, out_hi, out_lo}, 8'h2E);
        pulse_trig();
        check("R7 capture", {2'b00, out_hi, out_lo}, 8'h25);

        // R5 idle read returns zero
        #1 check("R5 idle rdata", bus_rdata, 8'h00);

        // R1 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_read(1'b1, v);  check("R1 buffer", v, 8'h00);
        check("R1 latch", {2'b00, out_hi, out_lo}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule